// File: doc/BRIEF.md
# OSD Memory Access Control Register

This block sits between a byte-wide host register port and the memories of an on-screen-display engine. It decodes each host address into one of several memory windows: two-colour attribute space, four-colour attribute and font space, the display page, or a small bank of control registers. It then produces the steering controls the memories need. A plane-select output picks one bit plane of four-colour data. A character-versus-attribute choice routes the correct byte back on reads of the display page.

One register in the bank holds the steering bits, the sync polarity selections and the vertical-blank detection limit. Setting its top bit starts a software reset. The reset runs for a fixed number of cycles and returns every other bank register to its default value. It leaves the steering register's own low bits as they are, and it clears its own bit when it finishes. Host transfers are not aborted by it.

Top module: `osd_access_ctrl`

## Requirements
- R1: After reset the control register at 0x8402 reads 0x00 and `sw_reset_o` is 0. The bank registers at 0x8400–0x8407 (other than 0x8402) read 0x0C at 0x8403, 0x51 at 0x8404 and 0x00 elsewhere.
- R2: `mem_rgn_o` encodes the host address window: 1 for 0x0000–0x2FFF, 2 for 0x3000–0x3FFF and 0x7000–0x7FFF, 3 for 0x8000–0x81FF, 4 for 0x8400–0x8407, and 0 for any other address.
- R3: `plane_sel_o` equals control bit 0 while `mem_rgn_o` is 2, and is 0 for every other window, including the two-colour window.
- R4: A read in window 3 returns `page_char_i` when control bit 1 is 0 and `page_attr_i` when it is 1. It returns 0x00 when `page_vld_i` is low. `page_attr_sel_o` mirrors control bit 1.
- R5: Bank registers are read and written at 0x8400+i for i = 0..7. In the control register, written values of bits 5 and 6 are discarded and those bits always read 0.
- R6: Writing the control register with bit 7 set raises `sw_reset_o` from the next cycle for exactly 4 cycles. Bit 7 reads 1 during that time and 0 afterwards.
- R7: While `sw_reset_o` is high, every bank register except the control register is forced to its R1 default and host writes to those registers are discarded. Control bits 0–4 keep the written value.
- R8: Control bits 2, 3 and 4 drive `hsync_neg_o`, `vsync_neg_o` and `vblank_only_o` respectively.
- R9: `host_rdata` is 0x00 when `host_rd` is low, and for reads in windows 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 16 | Host byte address |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read qualifier |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from the address |
| page_char_i | input | 8 | Character code from the display page RAM |
| page_attr_i | input | 8 | Attribute code from the display page RAM |
| page_vld_i | input | 1 | Display page RAM has returned data |
| mem_rgn_o | output | 3 | Decoded address window code |
| plane_sel_o | output | 1 | Bit-plane select for four-colour data |
| page_attr_sel_o | output | 1 | Display page read returns the attribute byte |
| hsync_neg_o | output | 1 | Horizontal sync input is active-low |
| vsync_neg_o | output | 1 | Vertical sync input is active-low |
| vblank_only_o | output | 1 | Data detection limited to vertical blanking |
| sw_reset_o | output | 1 | Software reset in progress |

## Verification
The assertions assume that `host_addr` is stable for the whole cycle in which `host_rd` or `host_wr` is high. They also assume that a write strobe lasts exactly one cycle, so no multi-cycle write can overlap the end of a software reset. The bench drives every host signal from the falling clock edge and drops `host_wr` after a single rising edge. It draws random addresses only from inside the defined windows or from their gaps, which keeps every access decodable.

// File: rtl/osd_acc_pkg.sv
// Package: shared window codes, control bit positions and register defaults
// for the OSD access control block. Assumes an 8-register bank.
package osd_acc_pkg;

    typedef enum logic [2:0] {
        RGN_NONE  = 3'd0,
        RGN_ATTR2 = 3'd1,
        RGN_FOUR  = 3'd2,
        RGN_PAGE  = 3'd3,
        RGN_REG   = 3'd4
    } rgn_e;

    localparam int CB_PLANE = 0;
    localparam int CB_ATTR  = 1;
    localparam int CB_HPOL  = 2;
    localparam int CB_VPOL  = 3;
    localparam int CB_LIMIT = 4;
    localparam int CB_SRST  = 7;
    localparam int CTRL_LOW_W = 5;

    // Default value of each bank register after reset or software reset.
    function automatic logic [7:0] bank_default(input int idx);
        case (idx)
            3:       return 8'h0C;
            4:       return 8'h51;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/osd_addr_decode.sv
// Address window decoder. Maps a host address to a window code and a bank
// index. Assumes REG_BASE is aligned to NREG so the index is the low bits.
module osd_addr_decode
    import osd_acc_pkg::*;
#(
    parameter int          AW        = 16,
    parameter int          NREG      = 8,
    parameter logic [15:0] ATTR2_HI  = 16'h2FFF,
    parameter logic [15:0] FOURA_LO  = 16'h3000,
    parameter logic [15:0] FOURA_HI  = 16'h3FFF,
    parameter logic [15:0] FOURB_LO  = 16'h7000,
    parameter logic [15:0] FOURB_HI  = 16'h7FFF,
    parameter logic [15:0] PAGE_LO   = 16'h8000,
    parameter logic [15:0] PAGE_HI   = 16'h81FF,
    parameter logic [15:0] REG_BASE  = 16'h8400,
    localparam int         IW        = $clog2(NREG)
) (
    input  logic [AW-1:0] addr,
    output rgn_e          rgn,
    output logic [IW-1:0] idx
);

    localparam logic [AW-1:0] REG_TOP = AW'(REG_BASE) + AW'(NREG - 1);

    // Window priority compare; windows do not overlap.
    always_comb begin
        if (addr <= AW'(ATTR2_HI))
            rgn = RGN_ATTR2;
        else if ((addr >= AW'(FOURA_LO) && addr <= AW'(FOURA_HI)) ||
                 (addr >= AW'(FOURB_LO) && addr <= AW'(FOURB_HI)))
            rgn = RGN_FOUR;
        else if (addr >= AW'(PAGE_LO) && addr <= AW'(PAGE_HI))
            rgn = RGN_PAGE;
        else if (addr >= AW'(REG_BASE) && addr <= REG_TOP)
            rgn = RGN_REG;
        else
            rgn = RGN_NONE;
    end

    assign idx = addr[IW-1:0];

endmodule

// File: rtl/osd_ctrl_reg.sv
// Steering control register with self-clearing software reset sequencer.
// Assumes write strobes last one cycle. Bits 5 and 6 are never stored.
module osd_ctrl_reg
    import osd_acc_pkg::*;
#(
    parameter  int SRST_CYC = 4,
    localparam int CW       = $clog2(SRST_CYC + 1) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_srst,
    input  logic [CTRL_LOW_W-1:0] wr_low,
    output logic [7:0]            ctrl_o,
    output logic                  busy_o
);

    logic [CTRL_LOW_W-1:0] low_q;
    logic                  srst_q;
    logic [CW-1:0]         cnt_q;

    // Store steering bits on every write, also while a reset runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_q <= '0;
        else if (wr_en)
            low_q <= wr_low;
    end

    // Start, count down and self-clear the software reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_q <= 1'b0;
            cnt_q  <= '0;
        end else if (srst_q) begin
            if (cnt_q == '0)
                srst_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end else if (wr_en && wr_srst) begin
            srst_q <= 1'b1;
            cnt_q  <= CW'(SRST_CYC - 1);
        end
    end

    assign ctrl_o = {srst_q, 2'b00, low_q};
    assign busy_o = srst_q;

    // Independent run-length counter for the reset window check.
    logic [CW-1:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (srst_q)
            run_q <= run_q + 1'b1;
        else
            run_q <= '0;
    end

    AST_SRST_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> run_q == CW'(SRST_CYC)); // R6

    AST_SRST_START: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_srst && !busy_o) |=> busy_o); // R6

endmodule

// File: rtl/osd_reg_bank.sv
// Plain byte register bank. The control slot is left empty (reads 0) since
// the steering register lives elsewhere. Software reset forces defaults.
module osd_reg_bank
    import osd_acc_pkg::*;
#(
    parameter  int NREG     = 8,
    parameter  int CTRL_OFS = 2,
    localparam int IW       = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy_i,
    input  logic          wr_en,
    input  logic [IW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata_o
);

    logic [7:0] q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == CTRL_OFS) begin : g_hole
            assign q[i] = 8'h00;
        end else begin : g_byte
            logic [7:0] r;
            // Hold, write, or restore default for one bank byte.
            always_ff @(posedge clk) begin
                if (!rst_n || busy_i)
                    r <= bank_default(i);
                else if (wr_en && idx == IW'(i))
                    r <= wdata;
            end
            assign q[i] = r;

            AST_BANK_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
                $past(busy_i) |-> r == bank_default(i)); // R7
        end
    end

    assign rdata_o = q[idx];

endmodule

// File: rtl/osd_access_ctrl.sv
// Top of the OSD access control block: decodes host addresses, steers plane
// and page selects, muxes read data. Assumes host_addr is stable while
// host_rd or host_wr is high.
module osd_access_ctrl
    import osd_acc_pkg::*;
#(
    parameter  int          AW       = 16,
    parameter  int          NREG     = 8,
    parameter  int          CTRL_OFS = 2,
    parameter  int          SRST_CYC = 4,
    parameter  logic [15:0] REG_BASE = 16'h8400,
    localparam int          IW       = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    input  logic [7:0]    page_char_i,
    input  logic [7:0]    page_attr_i,
    input  logic          page_vld_i,
    output logic [2:0]    mem_rgn_o,
    output logic          plane_sel_o,
    output logic          page_attr_sel_o,
    output logic          hsync_neg_o,
    output logic          vsync_neg_o,
    output logic          vblank_only_o,
    output logic          sw_reset_o
);

    rgn_e          rgn;
    logic [IW-1:0] idx;
    logic [7:0]    ctrl;
    logic [7:0]    bank_rd;
    logic          busy;
    logic          reg_wr;
    logic          ctrl_wr;

    osd_addr_decode #(.AW(AW), .NREG(NREG), .REG_BASE(REG_BASE)) u_dec (
        .addr (host_addr),
        .rgn  (rgn),
        .idx  (idx)
    );

    assign reg_wr  = host_wr && (rgn == RGN_REG);
    assign ctrl_wr = reg_wr && (idx == IW'(CTRL_OFS));

    osd_ctrl_reg #(.SRST_CYC(SRST_CYC)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_wr),
        .wr_srst (host_wdata[CB_SRST]),
        .wr_low  (host_wdata[CTRL_LOW_W-1:0]),
        .ctrl_o  (ctrl),
        .busy_o  (busy)
    );

    osd_reg_bank #(.NREG(NREG), .CTRL_OFS(CTRL_OFS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_i  (busy),
        .wr_en   (reg_wr && !ctrl_wr),
        .idx     (idx),
        .wdata   (host_wdata),
        .rdata_o (bank_rd)
    );

    // Read-data mux over window, page selector and bank slot.
    always_comb begin
        host_rdata = 8'h00;
        if (host_rd) begin
            case (rgn)
                RGN_PAGE: if (page_vld_i)
                              host_rdata = ctrl[CB_ATTR] ? page_attr_i : page_char_i;
                RGN_REG:  host_rdata = (idx == IW'(CTRL_OFS)) ? ctrl : bank_rd;
                default:  host_rdata = 8'h00;
            endcase
        end
    end

    assign mem_rgn_o       = rgn;
    assign plane_sel_o     = (rgn == RGN_FOUR) && ctrl[CB_PLANE];
    assign page_attr_sel_o = ctrl[CB_ATTR];
    assign hsync_neg_o     = ctrl[CB_HPOL];
    assign vsync_neg_o     = ctrl[CB_VPOL];
    assign vblank_only_o   = ctrl[CB_LIMIT];
    assign sw_reset_o      = busy;

    AST_PLANE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        plane_sel_o |-> mem_rgn_o == 3'd2); // R3

    AST_NO_READ_LEAK: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rd || mem_rgn_o < 3'd3) |-> host_rdata == 8'h00); // R9

    AST_RSV_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && mem_rgn_o == 3'd4 && host_addr[IW-1:0] == IW'(CTRL_OFS))
            |-> host_rdata[6:5] == 2'b00); // R5

endmodule

// File: tb/sim_osd_access_ctrl.sv
`timescale 1ns/1ps
module sim_osd_access_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [7:0]  page_char_i = '0;
    logic [7:0]  page_attr_i = '0;
    logic        page_vld_i = 1'b0;
    logic [2:0]  mem_rgn_o;
    logic        plane_sel_o, page_attr_sel_o, hsync_neg_o, vsync_neg_o;
    logic        vblank_only_o, sw_reset_o;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] m_bank [8];
    logic [7:0] m_ctrl = 8'h00;

    always #2.5 clk = ~clk;

    osd_access_ctrl u0 (.*);

    function automatic logic [7:0] dflt(input int i);
        return (i == 3) ? 8'h0C : (i == 4) ? 8'h51 : 8'h00;
    endfunction

    function automatic logic [2:0] exp_rgn(input logic [15:0] a);
        if (a <= 16'h2FFF) return 3'd1;
        if ((a >= 16'h3000 && a <= 16'h3FFF) || (a >= 16'h7000 && a <= 16'h7FFF)) return 3'd2;
        if (a >= 16'h8000 && a <= 16'h81FF) return 3'd3;
        if (a >= 16'h8400 && a <= 16'h8407) return 3'd4;
        return 3'd0;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
        host_addr = a; host_rd = 1'b1;
        #1;
        chk(req, host_rdata, exp);
        host_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 8; i++) m_bank[i] = dflt(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 8; i++) rd_chk("R1 reset bank", 16'h8400 + 16'(i), dflt(i));
        chk("R1 busy after reset", {7'd0, sw_reset_o}, 8'h00);

        // R2/R3/R9 directed window edges, plane bit set
        wr(16'h8402, 8'h01); m_ctrl = 8'h01;
        host_addr = 16'h2FFF; #1; chk("R2 two-colour top", {5'd0, mem_rgn_o}, 8'd1);
        chk("R3 plane off in two-colour", {7'd0, plane_sel_o}, 8'd0);
        host_addr = 16'h3000; #1; chk("R2 four-colour base", {5'd0, mem_rgn_o}, 8'd2);
        chk("R3 plane on in four-colour", {7'd0, plane_sel_o}, 8'd1);
        host_addr = 16'h7FFF; #1; chk("R3 plane font top", {7'd0, plane_sel_o}, 8'd1);
        host_addr = 16'h8200; #1; chk("R2 gap after page", {5'd0, mem_rgn_o}, 8'd0);
        host_addr = 16'h8408; #1; chk("R2 past bank", {5'd0, mem_rgn_o}, 8'd0);
        rd_chk("R9 read four-colour", 16'h3123, 8'h00);

        // R5 reserved bits, R8 sync bits
        wr(16'h8402, 8'h7C); m_ctrl = 8'h1C;
        rd_chk("R5 reserved bits read zero", 16'h8402, 8'h1C);
        chk("R8 sync/limit outputs", {5'd0, vblank_only_o, vsync_neg_o, hsync_neg_o}, 8'h07);

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [15:0] a;
            logic [7:0] d;
            op = int'($urandom_range(0, 4));
            d = 8'($urandom);
            if (op == 0) begin
                int i;
                i = int'($urandom_range(0, 7));
                if (i == 2) d[7] = 1'b0;
                wr(16'h8400 + 16'(i), d);
                if (i == 2) m_ctrl = {3'b000, d[4:0]}; else m_bank[i] = d;
                @(negedge clk);
                rd_chk("R5 bank readback", 16'h8400 + 16'(i), (i == 2) ? m_ctrl : m_bank[i]);
                chk("R8 ctrl outputs", {4'd0, vblank_only_o, vsync_neg_o, hsync_neg_o, page_attr_sel_o},
                    {4'd0, m_ctrl[4:1]});
            end else if (op == 1) begin
                @(negedge clk);
                page_char_i = 8'($urandom); page_attr_i = 8'($urandom);
                page_vld_i = 1'($urandom);
                a = 16'h8000 + 16'($urandom_range(0, 16'h1FF));
                rd_chk("R4 page read", a, !page_vld_i ? 8'h00 : (m_ctrl[1] ? page_attr_i : page_char_i));
            end else begin
                @(negedge clk);
                case (op)
                    2: a = 16'($urandom_range(0, 16'h3FFF));
                    3: a = 16'h7000 + 16'($urandom_range(0, 16'h0FFF));
                    default: a = 16'($urandom);
                endcase
                host_addr = a; #1;
                chk("R2 random window", {5'd0, mem_rgn_o}, {5'd0, exp_rgn(a)});
                chk("R3 random plane", {7'd0, plane_sel_o},
                    {7'd0, (exp_rgn(a) == 3'd2) && m_ctrl[0]});
                if (exp_rgn(a) < 3'd3) rd_chk("R9 non-data read", a, 8'h00);
                chk("R9 idle read data", host_rdata, 8'h00);
            end
        end

        // R6/R7 software reset
        for (int i = 0; i < 8; i++) if (i != 2) wr(16'h8400 + 16'(i), 8'hA5);
        @(negedge clk);
        host_addr = 16'h8402; host_wdata = 8'h93; host_wr = 1'b1;
        @(negedge clk);
        host_addr = 16'h8400; host_wdata = 8'h3C; host_wr = 1'b1;  // lands while busy
        #1; chk("R6 busy cycle 1", {7'd0, sw_reset_o}, 8'd1);
        host_wr = 1'b0;
        rd_chk("R6 bit7 reads one", 16'h8402, 8'h93);
        for (int k = 2; k <= 4; k++) begin
            @(negedge clk); #1;
            chk("R6 busy held", {7'd0, sw_reset_o}, 8'd1);
        end
        @(negedge clk); #1;
        chk("R6 busy cleared after 4", {7'd0, sw_reset_o}, 8'd0);
        rd_chk("R6 bit7 self-cleared", 16'h8402, 8'h13);
        for (int i = 0; i < 8; i++)
            if (i != 2) rd_chk("R7 bank restored", 16'h8400 + 16'(i), dflt(i));
        chk("R7 ctrl low bits kept", {6'd0, page_attr_sel_o, vblank_only_o}, 8'h03);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule